// File: doc/BRIEF.md
# Interrupt Queue Pointer Bank

This block keeps the head and tail pointers of four in-memory interrupt queues: CPU cross-call messages, device messages, resumable errors and non-resumable errors. Software (or a register access unit) writes any pointer through a single write port and reads any pointer back through a single read port. Each pointer has its own address.

For the first three queues the block raises a level interrupt request whenever the head and tail of that queue differ, meaning that the queue holds entries still to be serviced. The non-resumable error queue only stores its pointers and never requests an interrupt. The queue memory, the pointer wrap arithmetic and the trap delivery all sit outside this block.

Address map (4-bit address): bit 0 selects head (0) or tail (1). Bits 2:1 select the queue: 0 is CPU messages, 1 is device messages, 2 is resumable errors and 3 is non-resumable errors. Bit 3 must be 0. An address with bit 3 set is unmapped.

Top module: `irq_queue_ptr_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, all eight pointers are cleared to zero. After reset, every read of a mapped address returns 0 and all three interrupt outputs are low.
- R2: A write with `wr_en` high to a mapped address stores all 64 bits of `wr_data` at that clock edge. A read of that address then returns the stored value unchanged, with `rd_data` following `rd_addr` combinationally.
- R3: After any write, `irq_cpu_msg` is high exactly when the CPU message head (address 0) differs from its tail (address 1).
- R4: After any write, `irq_dev_msg` is high exactly when the device message head (address 2) differs from its tail (address 3).
- R5: After any write, `irq_res_err` is high exactly when the resumable error head (address 4) differs from its tail (address 5).
- R6: The non-resumable error pointers (head at address 6, tail at address 7) can be written and read back. Writing them never changes any interrupt output.
- R7: A write to an unmapped address (bit 3 set) changes no pointer and no interrupt output.
- R8: A read from an unmapped address (bit 3 set) returns zero.
- R9: The interrupt outputs are levels that follow the stored pointers from the cycle after each write edge, including back-to-back writes on consecutive cycles. A write to one queue never changes another queue's interrupt.
- R10: While `wr_en` is low, no pointer and no interrupt output changes, whatever the address and data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 64 | Read data (combinational from `rd_addr`) |
| irq_cpu_msg | output | 1 | CPU message queue not empty |
| irq_dev_msg | output | 1 | Device message queue not empty |
| irq_res_err | output | 1 | Resumable error queue not empty |

## Verification
A write takes effect at the rising edge where `wr_en` is sampled. The interrupt levels and the read data for an address depend only on registered pointers, so both are due straight after that same edge with no added latency. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge. Each check therefore sees the state left by exactly one write. For back-to-back writes, the bench checks after each of the two consecutive edges, which shows that no interrupt update lags behind by a cycle.

// File: rtl/irqq_pkg.sv
// Package: shared constants for the interrupt queue pointer bank.
// Assumes the queues that raise interrupts occupy the lowest indices and
// the silent (non-resumable error) queue is the last one.
package irqq_pkg;

    localparam int QUEUE_CNT     = 4;
    localparam int IRQ_QUEUE_CNT = 3;

    typedef enum logic [1:0] {
        Q_CPU_MSG  = 2'd0,
        Q_DEV_MSG  = 2'd1,
        Q_RES_ERR  = 2'd2,
        Q_NRES_ERR = 2'd3
    } queue_id_e;

endpackage

// File: rtl/irqq_wr_decode.sv
// Module: irqq_wr_decode
// Turns the write strobe and address into one write enable per head and
// per tail pointer. Assumes address bit 0 selects tail, bits SEL_W:1 pick
// the queue, and any higher bit set marks the address as unmapped.
module irqq_wr_decode #(
    parameter int ADDR_W    = 4,
    parameter int QUEUE_CNT = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [QUEUE_CNT-1:0] head_we,
    output logic [QUEUE_CNT-1:0] tail_we
);
    localparam int SEL_W = (QUEUE_CNT > 1) ? $clog2(QUEUE_CNT) : 1;

    logic             mapped;
    logic [SEL_W-1:0] sel;

    // Address split: upper bits must be clear for a mapped location.
    always_comb begin
        sel    = wr_addr[SEL_W:1];
        mapped = (wr_addr[ADDR_W-1:SEL_W+1] == '0) && (int'(sel) < QUEUE_CNT);
    end

    // One-hot enable generation for the addressed pointer.
    always_comb begin
        head_we = '0;
        tail_we = '0;
        if (wr_en && mapped) begin
            if (wr_addr[0]) begin
                tail_we[sel] = 1'b1;
            end else begin
                head_we[sel] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqq_queue_slot.sv
// Module: irqq_queue_slot
// Holds the head and tail pointers of one queue. Each pointer loads the
// shared write data when its own enable is high. Assumes the enables are
// never both high together.
module irqq_queue_slot #(
    parameter int PTR_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_we,
    input  logic             tail_we,
    input  logic [PTR_W-1:0] wr_data,
    output logic [PTR_W-1:0] head_q,
    output logic [PTR_W-1:0] tail_q
);

    // Head pointer register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
        end else if (head_we) begin
            head_q <= wr_data;
        end
    end

    // Tail pointer register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
        end else if (tail_we) begin
            tail_q <= wr_data;
        end
    end

endmodule

// File: rtl/irqq_pending.sv
// Module: irqq_pending
// Derives one level interrupt request per interrupting queue, asserted
// while that queue's head and tail differ. Queues at index IRQ_CNT and
// above are not looked at.
module irqq_pending #(
    parameter int PTR_W     = 64,
    parameter int QUEUE_CNT = 4,
    parameter int IRQ_CNT   = 3
) (
    input  logic [PTR_W-1:0] heads [QUEUE_CNT],
    input  logic [PTR_W-1:0] tails [QUEUE_CNT],
    output logic [IRQ_CNT-1:0] irq_vec
);

    for (genvar gi = 0; gi < IRQ_CNT; gi++) begin : g_cmp
        // Non-empty detection for queue gi.
        always_comb begin
            irq_vec[gi] = (heads[gi] != tails[gi]);
        end
    end

endmodule

// File: rtl/irqq_rd_mux.sv
// Module: irqq_rd_mux
// Selects the addressed pointer for the read port, using the same address
// layout as the write decoder. Unmapped addresses read as zero.
module irqq_rd_mux #(
    parameter int PTR_W     = 64,
    parameter int ADDR_W    = 4,
    parameter int QUEUE_CNT = 4
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [PTR_W-1:0]  heads [QUEUE_CNT],
    input  logic [PTR_W-1:0]  tails [QUEUE_CNT],
    output logic [PTR_W-1:0]  rd_data
);
    localparam int SEL_W = (QUEUE_CNT > 1) ? $clog2(QUEUE_CNT) : 1;

    logic [SEL_W-1:0] sel;
    logic             mapped;

    // Read address split and mapping check.
    always_comb begin
        sel    = rd_addr[SEL_W:1];
        mapped = (rd_addr[ADDR_W-1:SEL_W+1] == '0) && (int'(sel) < QUEUE_CNT);
    end

    // Pointer selection, forced to zero off the map.
    always_comb begin
        rd_data = '0;
        if (mapped) begin
            rd_data = rd_addr[0] ? tails[sel] : heads[sel];
        end
    end

endmodule

// File: rtl/irq_queue_ptr_bank.sv
// Module: irq_queue_ptr_bank (top)
// Register bank for the head/tail pointers of four interrupt queues. It
// raises a level interrupt for each of the first three queues while the
// queue is non-empty (head != tail). The non-resumable error queue is
// storage only. Assumes the caller issues at most one write per cycle.
module irq_queue_ptr_bank #(
    parameter int PTR_W  = 64,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PTR_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  rd_data,
    output logic              irq_cpu_msg,
    output logic              irq_dev_msg,
    output logic              irq_res_err
);
    import irqq_pkg::*;

    logic [QUEUE_CNT-1:0]     head_we;
    logic [QUEUE_CNT-1:0]     tail_we;
    logic [PTR_W-1:0]         heads [QUEUE_CNT];
    logic [PTR_W-1:0]         tails [QUEUE_CNT];
    logic [IRQ_QUEUE_CNT-1:0] irq_vec;

    irqq_wr_decode #(
        .ADDR_W    (ADDR_W),
        .QUEUE_CNT (QUEUE_CNT)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .head_we (head_we),
        .tail_we (tail_we)
    );

    for (genvar gq = 0; gq < QUEUE_CNT; gq++) begin : g_slot
        irqq_queue_slot #(
            .PTR_W (PTR_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .head_we (head_we[gq]),
            .tail_we (tail_we[gq]),
            .wr_data (wr_data),
            .head_q  (heads[gq]),
            .tail_q  (tails[gq])
        );
    end

    irqq_pending #(
        .PTR_W     (PTR_W),
        .QUEUE_CNT (QUEUE_CNT),
        .IRQ_CNT   (IRQ_QUEUE_CNT)
    ) u_pend (
        .heads   (heads),
        .tails   (tails),
        .irq_vec (irq_vec)
    );

    irqq_rd_mux #(
        .PTR_W     (PTR_W),
        .ADDR_W    (ADDR_W),
        .QUEUE_CNT (QUEUE_CNT)
    ) u_rd (
        .rd_addr (rd_addr),
        .heads   (heads),
        .tails   (tails),
        .rd_data (rd_data)
    );

    // Interrupt outputs, one per interrupting queue.
    always_comb begin
        irq_cpu_msg = irq_vec[Q_CPU_MSG];
        irq_dev_msg = irq_vec[Q_DEV_MSG];
        irq_res_err = irq_vec[Q_RES_ERR];
    end

endmodule

// File: rtl/irq_queue_ptr_bank_checker.sv
// Module: irq_queue_ptr_bank_checker
// Port-level properties of the pointer bank, attached by bind.
module irq_queue_ptr_bank_checker #(
    parameter int PTR_W  = 64,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [PTR_W-1:0]  rd_data,
    input logic              irq_cpu_msg,
    input logic              irq_dev_msg,
    input logic              irq_res_err
);
    logic [2:0] irqs;
    assign irqs = {irq_res_err, irq_dev_msg, irq_cpu_msg};

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irqs == 3'b000)); // R1

    AST_SILENT_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[ADDR_W-1:1] == 3'b011) |=> $stable(irqs)); // R6

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[ADDR_W-1]) |=> $stable(irqs)); // R7

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr[ADDR_W-1] |-> (rd_data == '0)); // R8

    AST_CPU_WRITE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[ADDR_W-1:1] == 3'b000) |=> $stable({irq_res_err, irq_dev_msg})); // R9

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(irqs)); // R10

endmodule

bind irq_queue_ptr_bank irq_queue_ptr_bank_checker #(
    .PTR_W  (PTR_W),
    .ADDR_W (ADDR_W)
) chk_i (.*);

// File: tb/irq_queue_ptr_bank_tb_top.sv
`timescale 1ns/1ps
module irq_queue_ptr_bank_tb_top;

    localparam int CLK_HALF = 10;
    localparam int NVEC     = 12;
    localparam int WDOG_CYC = 5000;

    typedef struct packed {
        logic        we;
        logic [3:0]  wa;
        logic [63:0] wd;
        logic [3:0]  ra;
        logic [63:0] exp_rd;
        logic [2:0]  exp_irq;   // {res_err, dev_msg, cpu_msg}
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'd0, 64'd5,                  4'd0, 64'd5,                  3'b001, 8'd3},  // R3 head differs
        '{1'b1, 4'd1, 64'd5,                  4'd1, 64'd5,                  3'b000, 8'd3},  // R3 equal again
        '{1'b1, 4'd3, 64'hDEADBEEF_00000001,  4'd3, 64'hDEADBEEF_00000001,  3'b010, 8'd4},  // R4
        '{1'b1, 4'd4, 64'd7,                  4'd4, 64'd7,                  3'b110, 8'd5},  // R5
        '{1'b1, 4'd6, 64'd9,                  4'd6, 64'd9,                  3'b110, 8'd6},  // R6 head
        '{1'b1, 4'd7, 64'hFFFFFFFF_FFFFFFFF,  4'd7, 64'hFFFFFFFF_FFFFFFFF,  3'b110, 8'd6},  // R6 tail
        '{1'b1, 4'd8, 64'd3,                  4'd0, 64'd5,                  3'b110, 8'd7},  // R7 alias of 0
        '{1'b0, 4'd5, 64'd7,                  4'd5, 64'd0,                  3'b110, 8'd10}, // R10
        '{1'b1, 4'd5, 64'd7,                  4'd5, 64'd7,                  3'b010, 8'd5},  // R5 drained
        '{1'b0, 4'd0, 64'd0,                  4'd9, 64'd0,                  3'b010, 8'd8},  // R8
        '{1'b1, 4'd2, 64'hDEADBEEF_00000001,  4'd2, 64'hDEADBEEF_00000001,  3'b000, 8'd4},  // R4 drained
        '{1'b1, 4'd0, 64'h80000000_00000005,  4'd0, 64'h80000000_00000005,  3'b001, 8'd2}   // R2 msb only
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        irq_cpu_msg, irq_dev_msg, irq_res_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    irq_queue_ptr_bank dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .irq_cpu_msg (irq_cpu_msg),
        .irq_dev_msg (irq_dev_msg),
        .irq_res_err (irq_res_err)
    );

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic [2:0] exp);
        chk64(tag, {61'd0, irq_res_err, irq_dev_msg, irq_cpu_msg}, {61'd0, exp});
    endtask

    // One write (or idle) cycle: drive on the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic we, input logic [3:0] wa, input logic [63:0] wd, input logic [3:0] ra);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all_zero(input string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 4'(a);
            #1;
            chk64(tag, rd_data, 64'd0);
        end
        chk_irq(tag, 3'b000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check_all_zero("R1 reset state");

        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].ra);
            wr_en = 1'b0;
            chk64($sformatf("R%0d vec%0d rd_data", VECS[i].req, i), rd_data, VECS[i].exp_rd);
            chk_irq($sformatf("R%0d vec%0d irq", VECS[i].req, i), VECS[i].exp_irq);
        end

        // R9: back-to-back writes, irq follows each edge (cpu head is 0x8000..05, tail 5).
        step(1'b1, 4'd1, 64'h80000000_00000005, 4'd1);
        chk_irq("R9 b2b first", 3'b000);
        step(1'b1, 4'd4, 64'd1, 4'd4);
        chk_irq("R9 b2b second", 3'b100);
        step(1'b1, 4'd5, 64'd1, 4'd5);
        chk_irq("R9 b2b third", 3'b000);
        wr_en = 1'b0;

        // R1: reset from a non-zero state.
        step(1'b1, 4'd2, 64'd44, 4'd2);
        wr_en = 1'b0;
        chk_irq("R1 pre-reset dev irq", 3'b010);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check_all_zero("R1 reset clears");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule